// File: doc/BRIEF.md
# Serial EEPROM Mode Control Register

This block is a byte-wide host register that decides how a network controller relates to its serial configuration EEPROM. A two-bit mode field picks one of four behaviours: ordinary operation, a self-clearing reload of settings from the EEPROM, direct software bit-banging of the EEPROM pins, and an unlock window for protected configuration writes. Behind it sits a small stand-in bank of configuration registers and a 16-bit PHY control register, whose writes the mode field gates.

The block is built around a five-state machine. `ST_NORMAL`, `ST_PROG` and `ST_CFGWR` are the resting states, and an accepted write to the mode register moves between them (code 00 goes to `ST_NORMAL`, 10 to `ST_PROG`, 11 to `ST_CFGWR`). Code 01 goes to `ST_LOAD`, which pulses a start strobe to an external loader and waits for either its done input or a cycle budget to run out, then moves to `ST_RELOAD`. `ST_RELOAD` lasts one cycle, pulses a register reset, and always returns to `ST_NORMAL`.

Top module: `eep_mode_ctl`

## Requirements
- R1: After reset the mode register reads 0x00, every configuration byte and the PHY control register hold their default values, and the EEPROM pin outputs, the start strobe, the register reset, the disable flag and the write-open flag are all low.
- R2: Mode codes live in bits 7:6 of address 0 (00 normal, 01 reload, 10 programming, 11 config-write) and read back there. Bits 5:4 always read 0 and writes to them are ignored.
- R3: Writing code 01 raises `ldr_start` for exactly the first cycle of the reload. While a reload runs, the mode reads 01 and host writes to the mode register are ignored.
- R4: A reload ends on `ldr_done` or after `LOAD_CYCLES` cycles, whichever is first. `regs_rst` then pulses for one cycle, the mode returns to 00, and all configuration bytes and the PHY register return to their defaults.
- R5: `net_disable` is high exactly while the mode is programming (10).
- R6: In programming mode `ee_cs`, `ee_sk` and `ee_di` follow mode-register bits 3, 2 and 1 as last written. Bit 0 reads the `ee_do` pin level, and writes to bit 0 are ignored.
- R7: Bits 3:0 of the mode register read {cs, sk, di, do} pin levels only during reload or programming, and read 0 otherwise. During reload the pins follow the loader's `ldr_cs`, `ldr_sk` and `ldr_di`. In normal and config-write modes the three pin outputs stay low.
- R8: Configuration bytes at addresses 1 to NUM_CFG accept writes only in config-write mode (11). Writes in any other mode leave them unchanged. `cfg_wr_open` is high exactly in that mode.
- R9: The PHY control register sits at addresses NUM_CFG+2 (low byte) and NUM_CFG+3 (high byte). Its bits 13, 12 and 8 (high-byte bits 5, 4 and 0) change only in config-write mode, and all its other bits are writable in any mode.
- R10: Unmapped addresses (address NUM_CFG+1) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | ADDR_W | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | ADDR_W | Host read address |
| host_rdata | output | 8 | Host read data (combinational) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM data in (to the EEPROM) |
| ee_do | input | 1 | EEPROM data out (from the EEPROM) |
| ldr_cs | input | 1 | Loader-driven chip select |
| ldr_sk | input | 1 | Loader-driven serial clock |
| ldr_di | input | 1 | Loader-driven data in |
| ldr_start | output | 1 | One-cycle start strobe to the loader |
| ldr_done | input | 1 | Loader completion |
| regs_rst | output | 1 | One-cycle register reset at reload end |
| net_disable | output | 1 | Network and bus-master disable |
| cfg_wr_open | output | 1 | Protected configuration writes allowed |

## Verification
The hardest situation to reach is the reload that ends on its cycle budget rather than on the loader's done input. The bench builds the design with a budget of 20 cycles, holds `ldr_done` low, and samples one cycle before and exactly at the expiry to catch an off-by-one. It also checks that a host write landing mid-reload leaves the mode untouched, by issuing that write while the loader's pin levels are visible in bits 3:0.

// File: rtl/eep_mode_pkg.sv
package eep_mode_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_LOAD,
        ST_RELOAD,
        ST_PROG,
        ST_CFGWR
    } mode_st_e;

    localparam logic [1:0] CODE_NORMAL = 2'b00;
    localparam logic [1:0] CODE_LOAD   = 2'b01;
    localparam logic [1:0] CODE_PROG   = 2'b10;
    localparam logic [1:0] CODE_CFGWR  = 2'b11;

endpackage

// File: rtl/eep_mode_fsm.sv
module eep_mode_fsm
    import eep_mode_pkg::*;
#(
    parameter int LOAD_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_code,
    input  logic       ldr_done,
    output mode_st_e   state,
    output logic       wr_accept,
    output logic       ldr_start,
    output logic       regs_rst,
    output logic       net_disable,
    output logic       cfg_open,
    output logic [1:0] mode_rd
);

    localparam int CNT_W = $clog2(LOAD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_CYCLES - 1);

    mode_st_e         nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL, ST_PROG, ST_CFGWR: begin
                if (mode_wr) begin
                    unique case (mode_code)
                        CODE_NORMAL: nxt = ST_NORMAL;
                        CODE_LOAD:   nxt = ST_LOAD;
                        CODE_PROG:   nxt = ST_PROG;
                        CODE_CFGWR:  nxt = ST_CFGWR;
                    endcase
                end
            end
            ST_LOAD: begin
                if (ldr_done || cnt == CNT_LAST) nxt = ST_RELOAD;
            end
            ST_RELOAD: nxt = ST_NORMAL;
            default:   nxt = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_LOAD) cnt <= cnt + 1'b1;
            else                  cnt <= '0;
        end
    end

    always_comb begin
        wr_accept   = mode_wr && (state != ST_LOAD) && (state != ST_RELOAD);
        ldr_start   = (state == ST_LOAD) && (cnt == '0);
        regs_rst    = (state == ST_RELOAD);
        net_disable = (state == ST_PROG);
        cfg_open    = (state == ST_CFGWR);
        unique case (state)
            ST_NORMAL:          mode_rd = CODE_NORMAL;
            ST_LOAD, ST_RELOAD: mode_rd = CODE_LOAD;
            ST_PROG:            mode_rd = CODE_PROG;
            ST_CFGWR:           mode_rd = CODE_CFGWR;
            default:            mode_rd = CODE_NORMAL;
        endcase
    end

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ldr_start |=> !ldr_start);

    p_load_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !ldr_done && cnt != CNT_LAST) |=> (state == ST_LOAD));

    p_load_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (cnt <= CNT_LAST));

    p_reload_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_rst |=> (!regs_rst && state == ST_NORMAL));

endmodule

// File: rtl/eep_pin_mux.sv
module eep_pin_mux
    import eep_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mode_st_e   state,
    input  logic       wr_accept,
    input  logic [2:0] wbits,
    input  logic       clr,
    input  logic       ldr_cs,
    input  logic       ldr_sk,
    input  logic       ldr_di,
    input  logic       ee_do,
    output logic       ee_cs,
    output logic       ee_sk,
    output logic       ee_di,
    output logic [3:0] pin_view
);

    logic [2:0] pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pin_q <= '0;
        else if (clr)       pin_q <= '0;
        else if (wr_accept) pin_q <= wbits;
    end

    always_comb begin
        unique case (state)
            ST_PROG:            {ee_cs, ee_sk, ee_di} = pin_q;
            ST_LOAD, ST_RELOAD: {ee_cs, ee_sk, ee_di} = {ldr_cs, ldr_sk, ldr_di};
            default:            {ee_cs, ee_sk, ee_di} = 3'b000;
        endcase
        if (state == ST_PROG || state == ST_LOAD || state == ST_RELOAD)
            pin_view = {ee_cs, ee_sk, ee_di, ee_do};
        else
            pin_view = 4'h0;
    end

    p_pins_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL || state == ST_CFGWR) |-> (!ee_cs && !ee_sk && !ee_di));

    p_prog_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && !clr) |=> (state != ST_PROG || {ee_cs, ee_sk, ee_di} == $past(wbits)));

endmodule

// File: rtl/eep_cfg_bank.sv
module eep_cfg_bank #(
    parameter int                    NUM_CFG      = 4,
    parameter int                    ADDR_W       = 3,
    parameter logic [NUM_CFG*8-1:0]  CFG_DEFAULTS = 32'h0C21608D,
    parameter logic [15:0]           PHY_DEFAULT  = 16'h1000,
    parameter logic [15:0]           PHY_LOCK     = 16'h3100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              open,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] A_PHY_LO = ADDR_W'(NUM_CFG + 2);
    localparam logic [ADDR_W-1:0] A_PHY_HI = ADDR_W'(NUM_CFG + 3);

    logic [NUM_CFG-1:0][7:0] cfg_q;
    logic [15:0]             phy_q;
    logic [7:0]              lock_lo, lock_hi;
    logic                    cfg_addr_w;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[g] <= CFG_DEFAULTS[g*8 +: 8];
            else if (clr)
                cfg_q[g] <= CFG_DEFAULTS[g*8 +: 8];
            else if (wr && open && waddr == ADDR_W'(g + 1))
                cfg_q[g] <= wdata;
        end
    end

    assign lock_lo = open ? 8'h00 : PHY_LOCK[7:0];
    assign lock_hi = open ? 8'h00 : PHY_LOCK[15:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phy_q <= PHY_DEFAULT;
        else if (clr)
            phy_q <= PHY_DEFAULT;
        else if (wr && waddr == A_PHY_LO)
            phy_q[7:0] <= (phy_q[7:0] & lock_lo) | (wdata & ~lock_lo);
        else if (wr && waddr == A_PHY_HI)
            phy_q[15:8] <= (phy_q[15:8] & lock_hi) | (wdata & ~lock_hi);
    end

    always_comb begin
        rdata = 8'h00;
        hit   = 1'b0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (raddr == ADDR_W'(i + 1)) begin
                rdata = cfg_q[i];
                hit   = 1'b1;
            end
        end
        if (raddr == A_PHY_LO) begin
            rdata = phy_q[7:0];
            hit   = 1'b1;
        end
        if (raddr == A_PHY_HI) begin
            rdata = phy_q[15:8];
            hit   = 1'b1;
        end
    end

    assign cfg_addr_w = (waddr >= ADDR_W'(1)) && (waddr <= ADDR_W'(NUM_CFG));

    p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !open && !clr && cfg_addr_w) |=> $stable(cfg_q));

    p_phy_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !clr) |=> ((phy_q & PHY_LOCK) == ($past(phy_q) & PHY_LOCK)));

endmodule

// File: rtl/eep_mode_ctl.sv
module eep_mode_ctl
    import eep_mode_pkg::*;
#(
    parameter int                    LOAD_CYCLES  = 100000,
    parameter int                    NUM_CFG      = 4,
    parameter int                    ADDR_W       = 3,
    parameter logic [NUM_CFG*8-1:0]  CFG_DEFAULTS = 32'h0C21608D,
    parameter logic [15:0]           PHY_DEFAULT  = 16'h1000,
    parameter logic [15:0]           PHY_LOCK     = 16'h3100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_waddr,
    input  logic [7:0]        host_wdata,
    input  logic [ADDR_W-1:0] host_raddr,
    output logic [7:0]        host_rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    input  logic              ldr_cs,
    input  logic              ldr_sk,
    input  logic              ldr_di,
    output logic              ldr_start,
    input  logic              ldr_done,
    output logic              regs_rst,
    output logic              net_disable,
    output logic              cfg_wr_open
);

    localparam logic [ADDR_W-1:0] A_MODE = '0;

    mode_st_e   state;
    logic       mode_wr;
    logic       wr_accept;
    logic [1:0] mode_rd;
    logic [3:0] pin_view;
    logic [7:0] cfg_rdata;
    logic       cfg_hit;

    assign mode_wr = host_wr && (host_waddr == A_MODE);

    eep_mode_fsm #(.LOAD_CYCLES(LOAD_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_code   (host_wdata[7:6]),
        .ldr_done    (ldr_done),
        .state       (state),
        .wr_accept   (wr_accept),
        .ldr_start   (ldr_start),
        .regs_rst    (regs_rst),
        .net_disable (net_disable),
        .cfg_open    (cfg_wr_open),
        .mode_rd     (mode_rd)
    );

    eep_pin_mux u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .wr_accept (wr_accept),
        .wbits     (host_wdata[3:1]),
        .clr       (regs_rst),
        .ldr_cs    (ldr_cs),
        .ldr_sk    (ldr_sk),
        .ldr_di    (ldr_di),
        .ee_do     (ee_do),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di),
        .pin_view  (pin_view)
    );

    eep_cfg_bank #(
        .NUM_CFG      (NUM_CFG),
        .ADDR_W       (ADDR_W),
        .CFG_DEFAULTS (CFG_DEFAULTS),
        .PHY_DEFAULT  (PHY_DEFAULT),
        .PHY_LOCK     (PHY_LOCK)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (regs_rst),
        .open  (cfg_wr_open),
        .wr    (host_wr),
        .waddr (host_waddr),
        .wdata (host_wdata),
        .raddr (host_raddr),
        .rdata (cfg_rdata),
        .hit   (cfg_hit)
    );

    always_comb begin
        if (host_raddr == A_MODE) host_rdata = {mode_rd, 2'b00, pin_view};
        else if (cfg_hit)         host_rdata = cfg_rdata;
        else                      host_rdata = 8'h00;
    end

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(net_disable && cfg_wr_open));

    p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_rst |-> (!net_disable && !cfg_wr_open && !ldr_start));

endmodule

// File: tb/tb_eep_mode_ctl.sv
module tb_eep_mode_ctl;

    localparam int           LOADC   = 20;
    localparam logic [31:0]  CFG_DEF = 32'h0C21608D;
    localparam logic [15:0]  PHY_DEF = 16'h1000;

    typedef struct packed {
        logic [2:0] wa;
        logic [7:0] wd;
        logic [2:0] ra;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'hC0, 3'd0, 8'hC0, 4'd2},   // R2 enter config-write
        '{3'd1, 8'h5A, 3'd1, 8'h5A, 4'd8},   // R8 open write
        '{3'd4, 8'hA5, 3'd4, 8'hA5, 4'd8},   // R8 open write last byte
        '{3'd7, 8'hFF, 3'd7, 8'hFF, 4'd9},   // R9 all bits when open
        '{3'd0, 8'h3F, 3'd0, 8'h00, 4'd2},   // R2 reserved and pins read 0 in normal
        '{3'd1, 8'h11, 3'd1, 8'h5A, 4'd8},   // R8 locked write ignored
        '{3'd7, 8'h00, 3'd7, 8'h31, 4'd9},   // R9 locked bits kept
        '{3'd6, 8'h77, 3'd6, 8'h77, 4'd9},   // R9 low byte free
        '{3'd0, 8'hC0, 3'd0, 8'hC0, 4'd2},
        '{3'd7, 8'h00, 3'd7, 8'h00, 4'd9},   // R9 unlocked clear
        '{3'd0, 8'h00, 3'd0, 8'h00, 4'd2},
        '{3'd2, 8'h33, 3'd2, 8'h60, 4'd8},   // R8 default kept
        '{3'd5, 8'hFF, 3'd5, 8'h00, 4'd10},  // R10 unmapped
        '{3'd0, 8'h8F, 3'd0, 8'h8E, 4'd6}    // R6 prog, bit0 write ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_waddr = '0;
    logic [7:0] host_wdata = '0;
    logic [2:0] host_raddr = '0;
    logic [7:0] host_rdata;
    logic       ee_cs, ee_sk, ee_di;
    logic       ee_do = 1'b0;
    logic       ldr_cs = 1'b0, ldr_sk = 1'b0, ldr_di = 1'b0;
    logic       ldr_start;
    logic       ldr_done = 1'b0;
    logic       regs_rst, net_disable, cfg_wr_open;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    eep_mode_ctl #(
        .LOAD_CYCLES  (LOADC),
        .NUM_CFG      (4),
        .ADDR_W       (3),
        .CFG_DEFAULTS (CFG_DEF),
        .PHY_DEFAULT  (PHY_DEF),
        .PHY_LOCK     (16'h3100)
    ) dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d); check("R1 mode", d, 8'h00);
        for (int i = 1; i <= 4; i++) begin
            rd(3'(i), d); check("R1 cfg default", d, CFG_DEF[(i-1)*8 +: 8]);
        end
        rd(3'd6, d); check("R1 phy lo", d, PHY_DEF[7:0]);
        rd(3'd7, d); check("R1 phy hi", d, PHY_DEF[15:8]);
        check("R1 outputs", {ee_cs, ee_sk, ee_di, ldr_start, regs_rst, net_disable, cfg_wr_open}, 8'h00);

        // table walk
        for (int v = 0; v < NV; v++) begin
            wr(VECS[v].wa, VECS[v].wd);
            rd(VECS[v].ra, d);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), d, VECS[v].exp);
            if (VECS[v].wa == 3'd0 && VECS[v].wd[7:6] == 2'b11)
                check("R8 open flag", {7'd0, cfg_wr_open}, 8'h01);
        end

        // programming mode: R5 R6
        check("R5 disable in prog", {7'd0, net_disable}, 8'h01);
        check("R8 closed in prog", {7'd0, cfg_wr_open}, 8'h00);
        check("R6 pins 111", {5'd0, ee_cs, ee_sk, ee_di}, 8'h07);
        ee_do = 1'b1;
        rd(3'd0, d); check("R6 do visible", d, 8'h8F);
        wr(3'd0, 8'h84);
        check("R6 pins 010", {5'd0, ee_cs, ee_sk, ee_di}, 8'h02);
        rd(3'd0, d); check("R7 prog view", d, 8'h85);
        ee_do = 1'b0;

        // reload ended by done: R3 R4 R7
        ldr_cs = 1'b1; ldr_sk = 1'b0; ldr_di = 1'b1;
        wr(3'd0, 8'h40);
        check("R3 start pulse", {7'd0, ldr_start}, 8'h01);
        check("R5 no disable in reload", {7'd0, net_disable}, 8'h00);
        rd(3'd0, d); check("R7 loader pins", d, 8'h4A);
        wr(3'd0, 8'hC0);
        check("R3 start single", {7'd0, ldr_start}, 8'h00);
        rd(3'd0, d); check("R3 write ignored in reload", d, 8'h4A);
        ldr_done = 1'b1;
        @(negedge clk);
        ldr_done = 1'b0;
        check("R4 reset pulse", {7'd0, regs_rst}, 8'h01);
        @(negedge clk);
        check("R4 pulse one cycle", {7'd0, regs_rst}, 8'h00);
        rd(3'd0, d); check("R4 mode back 00", d, 8'h00);
        rd(3'd1, d); check("R4 cfg default", d, CFG_DEF[7:0]);
        rd(3'd4, d); check("R4 cfg default", d, CFG_DEF[31:24]);
        rd(3'd6, d); check("R4 phy lo default", d, PHY_DEF[7:0]);
        rd(3'd7, d); check("R4 phy hi default", d, PHY_DEF[15:8]);
        check("R7 pins idle", {5'd0, ee_cs, ee_sk, ee_di}, 8'h00);

        // reload ended by budget: R4
        ldr_cs = 1'b0; ldr_sk = 1'b0; ldr_di = 1'b0;
        wr(3'd0, 8'h40);
        repeat (LOADC - 1) @(negedge clk);
        check("R4 not yet expired", {7'd0, regs_rst}, 8'h00);
        rd(3'd0, d); check("R4 still reloading", d, 8'h40);
        @(negedge clk);
        check("R4 budget expiry", {7'd0, regs_rst}, 8'h01);
        @(negedge clk);
        rd(3'd0, d); check("R4 mode 00 after budget", d, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule